// File: doc/BRIEF.md
# Coherent Two-Byte Measurement Register Bank

This block holds the latest voltage and temperature results of a measurement front end. It presents them to a host as byte-addressed, read-only registers. Each result is an 11-bit two's-complement sample. It is kept in a 16-bit register, left-justified, and the register is exposed as a high byte and a low byte. Voltage samples update their register as soon as they arrive. Temperature samples are held in a staging register and committed on a fixed period counted in clock cycles. The nominal temperature period is 220 ms, with 0.125 °C per LSB over a range of about ±127 °C.

The host frames each access with a command-start strobe and a command-end strobe, and issues byte reads in between. Reading the high byte of a pair takes a snapshot of the whole pair. Later reads of that pair within the same command return the snapshot, so a sample that lands between the two byte reads cannot produce a torn value. The live register keeps updating underneath the snapshot. Once the command closes, the new value becomes visible.

Top module: `meas_pair_bank`

## Requirements
- R1: After reset every register reads 0x00.
- R2: A sample s (11 bits, two's complement) is stored as {s, 5'b00000}. The high-byte address returns bits 15:8 and the low-byte address returns bits 7:0. Voltage uses 0x0C (high) and 0x0D (low); temperature uses 0x18 (high) and 0x19 (low).
- R3: A voltage sample with its valid strobe high is readable from the next cycle on.
- R4: The period counter starts at 0 after reset and asserts an internal tick every TEMP_PERIOD cycles. The first tick falls in cycle TEMP_PERIOD-1. On a tick, the temperature register loads the newest sample received in or before that cycle. If no sample has arrived since the previous load, the register is left unchanged. Between ticks it never changes.
- R5: A read of a pair's high byte captures both bytes in the same cycle. Until the latch is released, later reads of that pair return the captured bytes.
- R6: Samples that arrive while a pair is latched still update the live register. They become readable once the latch is released.
- R7: A command-start or command-end strobe releases every latch at the next edge. It takes priority over a high-byte read in the same cycle, and that read then captures nothing.
- R8: A low-byte read of a pair that is not latched returns the live low byte.
- R9: A second high-byte read while its pair is already latched does not refresh the snapshot.
- R10: Any address outside the four pair addresses reads 0x00.
- R11: Bits 4:0 of every low byte read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Host command begins; releases latches |
| cmd_end_i | input | 1 | Host command ends; releases latches |
| rd_en_i | input | 1 | Byte read strobe |
| rd_addr_i | input | 8 | Byte address of the read |
| rd_data_o | output | 8 | Read data, valid in the cycle of rd_en_i |
| volt_vld_i | input | 1 | Voltage sample valid |
| volt_smp_i | input | 11 | Voltage sample, two's complement |
| temp_vld_i | input | 1 | Temperature sample valid |
| temp_smp_i | input | 11 | Temperature sample, two's complement |

## Verification
The assertions assume that the host reads only between a command-start strobe and the matching command-end strobe. The snapshot-hold property also relies on sample strobes being one-cycle pulses that may arrive at any time, including in the same cycle as a read or a release. The stimulus frames every random command with a start strobe and an end strobe. Inside the command it mixes reads of mapped and unmapped addresses with independent random sample strobes, so samples regularly land between the two byte reads and in tick cycles. Directed sequences cover the strobe collisions that matter: a read in the same cycle as a release, a repeated high-byte read, and a low-byte read without a latch.

// File: rtl/meas_pair_pkg.sv
package meas_pair_pkg;
  localparam int unsigned SMP_W  = 11;
  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_VOLT = 0;
  localparam int unsigned CH_TEMP = 1;

  typedef logic [REG_W-1:0]  pair_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/meas_period_timer.sv
module meas_period_timer #(
  parameter int unsigned PERIOD = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R4
  tick_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
  // R4
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && (PERIOD > 1)) |=> !tick_o);
endmodule

// File: rtl/meas_pair_chan.sv
module meas_pair_chan
  import meas_pair_pkg::*;
#(
  parameter bit PERIODIC = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic [SMP_W-1:0] smp_i,
  input  logic             tick_i,
  input  logic             msb_rd_i,
  input  logic             release_i,
  output pair_t            view_o
);
  localparam int unsigned PAD_W = REG_W - SMP_W;

  pair_t            live_q, snap_q;
  logic             lat_q;
  logic             load;
  logic [SMP_W-1:0] load_val;

  generate
    if (PERIODIC) begin : g_staged
      logic [SMP_W-1:0] stage_q;
      logic             stage_vld_q;

      assign load     = tick_i && (smp_vld_i || stage_vld_q);
      assign load_val = smp_vld_i ? smp_i : stage_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stage_q     <= '0;
          stage_vld_q <= 1'b0;
        end else begin
          if (smp_vld_i) stage_q <= smp_i;
          if (load)           stage_vld_q <= 1'b0;
          else if (smp_vld_i) stage_vld_q <= 1'b1;
        end
      end

      // R4
      off_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(live_q));
    end else begin : g_direct
      assign load     = smp_vld_i;
      assign load_val = smp_i;

      // R3
      direct_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_vld_i |=> (live_q[REG_W-1:PAD_W] == $past(smp_i)));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   live_q <= '0;
    else if (load) live_q <= {load_val, {PAD_W{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q  <= 1'b0;
      snap_q <= '0;
    end else if (release_i) begin
      lat_q  <= 1'b0;
    end else if (msb_rd_i && !lat_q) begin
      lat_q  <= 1'b1;
      snap_q <= live_q;
    end
  end

  assign view_o = lat_q ? snap_q : live_q;

  // R5
  snap_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msb_rd_i && !lat_q && !release_i) |=> (lat_q && snap_q == $past(live_q)));
  // R9
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_q && !release_i) |=> (lat_q && $stable(snap_q)));
  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> !lat_q);
  // R11
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    view_o[PAD_W-1:0] == '0);
endmodule

// File: rtl/meas_rd_decode.sv
module meas_rd_decode
  import meas_pair_pkg::*;
#(
  parameter logic [NUM_CH-1:0][ADDR_W-1:0] MSB_ADDRS = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  addr_t             rd_addr_i,
  input  pair_t             view_i [NUM_CH],
  output logic [NUM_CH-1:0] msb_rd_o,
  output byte_t             rd_data_o
);
  logic [NUM_CH-1:0] hi_hit, lo_hit;
  byte_t             ch_byte [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign hi_hit[c]  = rd_en_i && (rd_addr_i == MSB_ADDRS[c]);
    assign lo_hit[c]  = rd_en_i && (rd_addr_i == MSB_ADDRS[c] + 8'd1);
    assign ch_byte[c] = hi_hit[c] ? view_i[c][REG_W-1:BYTE_W]
                      : lo_hit[c] ? view_i[c][BYTE_W-1:0] : '0;
  end

  assign msb_rd_o = hi_hit;

  always_comb begin
    rd_data_o = '0;
    for (int c = 0; c < NUM_CH; c++) rd_data_o = rd_data_o | ch_byte[c];
  end

  // R5
  one_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hi_hit, lo_hit}));
  // R10
  miss_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_hit == '0 && lo_hit == '0) |-> (rd_data_o == '0));
endmodule

// File: rtl/meas_pair_bank.sv
module meas_pair_bank
  import meas_pair_pkg::*;
#(
  parameter int unsigned TEMP_PERIOD   = 1000,
  parameter logic [7:0]  VOLT_MSB_ADDR = 8'h0C,
  parameter logic [7:0]  TEMP_MSB_ADDR = 8'h18
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_start_i,
  input  logic        cmd_end_i,
  input  logic        rd_en_i,
  input  logic [7:0]  rd_addr_i,
  output logic [7:0]  rd_data_o,
  input  logic        volt_vld_i,
  input  logic [10:0] volt_smp_i,
  input  logic        temp_vld_i,
  input  logic [10:0] temp_smp_i
);
  localparam logic [NUM_CH-1:0][ADDR_W-1:0] MSB_ADDRS = {TEMP_MSB_ADDR, VOLT_MSB_ADDR};

  logic              tick;
  logic              release_all;
  logic [NUM_CH-1:0] msb_rd;
  logic [NUM_CH-1:0] smp_vld;
  logic [SMP_W-1:0]  smp [NUM_CH];
  pair_t             view [NUM_CH];

  assign release_all = cmd_start_i || cmd_end_i;
  assign smp_vld     = {temp_vld_i, volt_vld_i};
  assign smp[CH_VOLT] = volt_smp_i;
  assign smp[CH_TEMP] = temp_smp_i;

  meas_period_timer #(.PERIOD(TEMP_PERIOD)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    meas_pair_chan #(.PERIODIC(c == CH_TEMP)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .smp_vld_i (smp_vld[c]),
      .smp_i     (smp[c]),
      .tick_i    (tick),
      .msb_rd_i  (msb_rd[c]),
      .release_i (release_all),
      .view_o    (view[c])
    );
  end

  meas_rd_decode #(.MSB_ADDRS(MSB_ADDRS)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .view_i    (view),
    .msb_rd_o  (msb_rd),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: tb/tb_meas_pair_bank.sv
`timescale 1ns/1ps
module tb_meas_pair_bank;
  localparam int P = 16;
  logic clk = 0, rst_n = 0;
  logic cs = 0, ce = 0, rd = 0, vv = 0, tv = 0;
  logic [7:0] addr = 0;
  logic [7:0] rdata;
  logic [10:0] vs = 0, ts = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  meas_pair_bank #(.TEMP_PERIOD(P)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(cs), .cmd_end_i(ce),
    .rd_en_i(rd), .rd_addr_i(addr), .rd_data_o(rdata),
    .volt_vld_i(vv), .volt_smp_i(vs), .temp_vld_i(tv), .temp_smp_i(ts));

  // independent model
  logic [15:0] m_live [2], m_snap [2];
  bit m_lat [2];
  logic [10:0] m_stage;
  bit m_svld;
  int m_cnt;
  logic [7:0] maddr [2] = '{8'h0C, 8'h18};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin m_live[c] = 0; m_snap[c] = 0; m_lat[c] = 0; end
      m_stage = 0; m_svld = 0; m_cnt = 0;
    end else begin
      bit tk;
      tk = (m_cnt == P-1);
      m_cnt = tk ? 0 : m_cnt + 1;
      if (cs || ce) begin
        for (int c = 0; c < 2; c++) m_lat[c] = 0;
      end else begin
        for (int c = 0; c < 2; c++)
          if (rd && addr == maddr[c] && !m_lat[c]) begin m_snap[c] = m_live[c]; m_lat[c] = 1; end
      end
      if (vv) m_live[0] = {vs, 5'b0};
      if (tk && (tv || m_svld)) begin
        m_live[1] = {(tv ? ts : m_stage), 5'b0};
        m_svld = 0;
      end else if (tv) m_svld = 1;
      if (tv) m_stage = ts;
    end
  end

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    for (int c = 0; c < 2; c++) begin
      logic [15:0] v;
      v = m_lat[c] ? m_snap[c] : m_live[c];
      if (a == maddr[c]) return v[15:8];
      if (a == maddr[c] + 8'd1) return v[7:0];
    end
    return 8'h00;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(bit s, bit e, bit r, logic [7:0] a, bit v1, logic [10:0] d1,
                      bit t1, logic [10:0] d2, string req);
    @(negedge clk);
    cs = s; ce = e; rd = r; addr = a; vv = v1; vs = d1; tv = t1; ts = d2;
    #1;
    if (r) begin
      check(req, rdata, exp_rd(a));
      if (a == 8'h0D || a == 8'h19) check("R11", rdata & 8'h1F, 8'h00);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    #12 rst_n = 1;
    // R1 reset values
    step(1, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 1, 8'h0C, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 8'h18, 0, 0, 0, 0, "R1");
    step(0, 1, 0, 0, 0, 0, 0, 0, "");
    check("R1", exp_rd(8'h0D), 8'h00);
    // R2 R3 voltage format and immediate update
    step(0, 0, 0, 0, 1, 11'h5A3, 0, 0, "");
    step(0, 0, 1, 8'h0C, 0, 0, 0, 0, "R3");
    check("R2", rdata, 8'hB4);
    step(0, 0, 1, 8'h0D, 0, 0, 0, 0, "R2");
    check("R2", rdata, 8'h60);
    step(0, 1, 0, 0, 0, 0, 0, 0, "");
    // R5 R6 R9 latch across mid-read sample
    step(1, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 1, 8'h0C, 1, 11'h123, 0, 0, "R5");
    step(0, 0, 0, 0, 1, 11'h3FF, 0, 0, "");
    step(0, 0, 1, 8'h0C, 0, 0, 0, 0, "R9");
    check("R9", rdata, 8'hB4);
    step(0, 0, 1, 8'h0D, 0, 0, 0, 0, "R5");
    check("R5", rdata, 8'h60);
    step(0, 1, 0, 0, 0, 0, 0, 0, "");
    step(1, 0, 1, 8'h0C, 0, 0, 0, 0, "R6");
    check("R6", rdata, 8'h7F);
    // R7 release wins over same-cycle MSB read: LSB then live
    step(0, 0, 0, 0, 1, 11'h001, 0, 0, "");
    step(0, 0, 1, 8'h0D, 0, 0, 0, 0, "R7");
    check("R7", rdata, 8'h20);
    // R8 LSB without MSB read gives live
    step(0, 0, 0, 0, 1, 11'h002, 0, 0, "");
    step(0, 0, 1, 8'h0D, 0, 0, 0, 0, "R8");
    check("R8", rdata, 8'h40);
    step(0, 1, 0, 0, 0, 0, 0, 0, "");
    // R10 unmapped
    step(1, 0, 1, 8'h0E, 0, 0, 0, 0, "R10");
    check("R10", rdata, 8'h00);
    step(0, 0, 1, 8'h1A, 0, 0, 0, 0, "R10");
    step(0, 0, 1, 8'hFF, 0, 0, 0, 0, "R10");
    step(0, 1, 0, 0, 0, 0, 0, 0, "");
    // R4 temperature: -127 C = -1016 committed only on tick
    step(0, 0, 0, 0, 0, 0, 1, 11'h408, "");
    for (int i = 0; i < P + 2; i++) begin
      step(1, 0, 1, 8'h18, 0, 0, 0, 0, "R4");
      step(0, 1, 1, 8'h19, 0, 0, 0, 0, "R4");
    end
    step(1, 0, 1, 8'h18, 0, 0, 0, 0, "R4");
    check("R4", rdata, 8'h81);
    step(0, 1, 0, 0, 0, 0, 0, 0, "");
    // random commands
    for (int k = 0; k < 1500; k++) begin
      int len;
      len = 1 + ($urandom % 6);
      step(1, 0, 0, 0, 0, 0, 0, 0, "");
      for (int j = 0; j < len; j++) begin
        logic [7:0] a;
        case ($urandom % 5)
          0: a = 8'h0C; 1: a = 8'h0D; 2: a = 8'h18; 3: a = 8'h19;
          default: a = 8'($urandom);
        endcase
        step(0, 0, ($urandom % 4) != 0, a, ($urandom % 3) == 0, 11'($urandom),
             ($urandom % 3) == 0, 11'($urandom), "R5");
      end
      step(0, 1, 0, 0, ($urandom % 2) == 0, 11'($urandom), 0, 0, "");
    end
    idle(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule